// File: doc/BRIEF.md
# Pipelined Interval Timer

A down-counting interval timer whose control bits pass through fixed delay stages on their way into the count logic. Software writes a reload value as two bytes, then a control byte. The control byte starts or stops counting, selects one-shot or continuous mode, forces a reload, and picks the count source. The source is either every system clock or an external step strobe. Every control action takes effect one or two cycles after the write. Code that depends on exact cycle counts sees the same latencies on every access.

The counter counts down from the reload value. An underflow occurs in the cycle where the counter would reach zero. In that cycle the block pulses `underflow_o` and reloads the counter from the latch, and the decrement in the following cycle is suppressed. This gives a period of reload value plus one. In one-shot mode the same cycle also clears the start bit, so the timer stops.

Top module: `ivt_timer`

## Requirements
- R1: After reset the counter reads all ones, `underflow_o` is 0 and `start_o` is 0.
- R2: A control write with bit 4 (force reload) set copies the latch into the counter on the second clock edge after the write; the write edge itself leaves the counter unchanged.
- R3: A write to address 1 (latch upper byte) while the start bit is clear reloads the counter with the same two-edge delay as R2. A write to address 0 (latch low byte) changes only the latch and never the counter.
- R4: A control write to address 2 with bit 0 (start) and bit 5 (count system clock) set causes the first decrement on the second edge after the write edge. The counter then drops by exactly one per edge, and it does not change on an edge without a pending decrement or reload.
- R5: On the edge where a decrement would leave zero, `underflow_o` is 1 for that one cycle and the counter shows the latch value. In continuous mode underflows then recur every latch+1 cycles. With a latch of 0 this is every cycle.
- R6: With a latch value of 1 in continuous mode, the underflow pulse appears on every second cycle.
- R7: With control bit 3 (one-shot) set, `start_o` falls on the same edge that raises `underflow_o`. No further underflow follows, and the counter keeps the latch value.
- R8: With bit 5 clear and start set, each edge that sees `step_i` high causes exactly one decrement on the next edge. Without steps the counter holds.
- R9: A control write that clears the start bit while counting on the system clock lets two more decrements happen: one on the write edge and one on the edge after it. The counter then holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 latch low byte, 1 latch upper byte, 2 control, 3 unused |
| wr_data | input | 8 | Write data |
| step_i | input | 1 | External count-step strobe |
| count_o | output | CNT_W | Current counter value |
| underflow_o | output | 1 | One-cycle underflow pulse |
| start_o | output | 1 | Start bit as held by the timer |

## Verification
The bench builds the timer with a 10-bit counter. At that width the reset value of 1023 and the upper-byte path are both exercised, while the reload values stay small. The bench sweeps reload values 0 through 6 in continuous mode and compares every cycle's counter value and underflow against the period formula. This puts the degenerate period-one and period-two cases within reach of the same check. Separate runs cover one-shot stop, external stepping with single and held strobes, stop latency, and the two-edge reload delay.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] SEL_LATCH_LO = 2'd0;
  localparam logic [1:0] SEL_LATCH_HI = 2'd1;
  localparam logic [1:0] SEL_CTRL     = 2'd2;

  localparam int CB_START   = 0;
  localparam int CB_ONESHOT = 3;
  localparam int CB_FLOAD   = 4;
  localparam int CB_SYSCLK  = 5;

  // Control pipeline of the timer, one bit per delay stage.
  typedef struct packed {
    logic start;    // run request as held by the timer
    logic oneshot;  // one-shot mode request
    logic sysclk;   // count source: system clock
    logic run2;     // first counting stage
    logic run3;     // decrement enable
    logic run;      // delayed copy of run3
    logic ld1;      // first reload stage
    logic ld2;      // reload applied
    logic os1;      // first one-shot stage
    logic os2;      // second one-shot stage
  } pipe_t;

  localparam pipe_t PIPE_IDLE = '0;

  // Plain advance of every stage by one cycle.
  function automatic pipe_t pipe_step(input pipe_t cur, input logic fload,
                                      input logic step);
    pipe_t nx;
    nx         = PIPE_IDLE;
    nx.start   = cur.start;
    nx.oneshot = cur.oneshot;
    nx.sysclk  = cur.sysclk;
    nx.run2    = cur.start & cur.sysclk;
    nx.run3    = cur.run2 | (cur.start & step);
    nx.run     = cur.run3;
    nx.ld1     = fload;
    nx.ld2     = cur.ld1;
    nx.os1     = cur.oneshot;
    nx.os2     = cur.os1;
    return nx;
  endfunction

  // Corrections applied after the advance: reload and one-shot stop.
  function automatic pipe_t pipe_settle(input pipe_t adv, input logic load,
                                        input logic uflow);
    pipe_t r;
    r = adv;
    if (load) r.run3 = 1'b0;
    if (uflow && (adv.os1 || adv.os2)) begin
      r.start = 1'b0;
      r.run2  = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs import ivt_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                running,
  output logic [CNT_W-1:0]    latch_q,
  output logic                ctrl_wr,
  output logic                reload_req
);

  localparam int HI_W = CNT_W - BYTE_W;

  logic wr_lo, wr_hi;

  assign wr_lo      = wr_en && (wr_addr == SEL_LATCH_LO);
  assign wr_hi      = wr_en && (wr_addr == SEL_LATCH_HI);
  assign ctrl_wr    = wr_en && (wr_addr == SEL_CTRL);
  assign reload_req = wr_hi && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
    end else begin
      if (wr_lo) latch_q[BYTE_W-1:0]     <= wr_data;
      if (wr_hi) latch_q[CNT_W-1:BYTE_W] <= wr_data[HI_W-1:0];
    end
  end

endmodule

// File: rtl/ivt_seq.sv
module ivt_seq import ivt_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  ctrl_wr,
  input  logic  c_start,
  input  logic  c_oneshot,
  input  logic  c_fload,
  input  logic  c_sysclk,
  input  logic  reload_req,
  input  logic  step_i,
  input  logic  zero_after,
  output pipe_t pipe_q,
  output logic  load_now,
  output logic  uflow_now
);

  pipe_t pipe_cur, pipe_adv, pipe_d;
  logic  fload_in, step_eff;

  always_comb begin
    pipe_cur = pipe_q;
    if (ctrl_wr) begin
      pipe_cur.start   = c_start;
      pipe_cur.oneshot = c_oneshot;
      pipe_cur.sysclk  = c_sysclk;
    end
    fload_in  = (ctrl_wr && c_fload) || reload_req;
    step_eff  = step_i && !pipe_cur.sysclk;
    pipe_adv  = pipe_step(pipe_cur, fload_in, step_eff);
    uflow_now = zero_after && pipe_adv.run3;
    load_now  = pipe_adv.ld2 || uflow_now;
    pipe_d    = pipe_settle(pipe_adv, load_now, uflow_now);
  end

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= PIPE_IDLE;
    else     pipe_q <= pipe_d;
  end

endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_en,
  input  logic             load_now,
  input  logic [CNT_W-1:0] latch_q,
  output logic [CNT_W-1:0] count_q,
  output logic             zero_after
);

  function automatic logic [CNT_W-1:0] dec_once(input logic [CNT_W-1:0] v,
                                                input logic en);
    return (en && (v != '0)) ? v - CNT_W'(1) : v;
  endfunction

  logic [CNT_W-1:0] after_dec;

  assign after_dec  = dec_once(count_q, dec_en);
  assign zero_after = (after_dec == '0);

  always_ff @(posedge clk) begin
    if (rst)           count_q <= '1;
    else if (load_now) count_q <= latch_q;
    else               count_q <= after_dec;
  end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer import ivt_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              step_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              underflow_o,
  output logic              start_o
);

  logic [CNT_W-1:0] latch_q;
  logic             ctrl_wr, reload_req;
  logic             load_now, uflow_now, zero_after;
  pipe_t            pipe_q;

  // Named internal events for the checker.
  logic run3_w, ld1_w, os_any_w;
  assign run3_w   = pipe_q.run3;
  assign ld1_w    = pipe_q.ld1;
  assign os_any_w = pipe_q.os1 || pipe_q.os2;

  ivt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .running    (pipe_q.start),
    .latch_q    (latch_q),
    .ctrl_wr    (ctrl_wr),
    .reload_req (reload_req)
  );

  ivt_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .c_start    (wr_data[CB_START]),
    .c_oneshot  (wr_data[CB_ONESHOT]),
    .c_fload    (wr_data[CB_FLOAD]),
    .c_sysclk   (wr_data[CB_SYSCLK]),
    .reload_req (reload_req),
    .step_i     (step_i),
    .zero_after (zero_after),
    .pipe_q     (pipe_q),
    .load_now   (load_now),
    .uflow_now  (uflow_now)
  );

  ivt_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .dec_en     (pipe_q.run3),
    .load_now   (load_now),
    .latch_q    (latch_q),
    .count_q    (count_o),
    .zero_after (zero_after)
  );

  always_ff @(posedge clk) begin
    if (rst) underflow_o <= 1'b0;
    else     underflow_o <= uflow_now;
  end

  assign start_o = pipe_q.start;

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             underflow_o,
  input logic             start_o,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] latch_q,
  input logic             run3_w,
  input logic             ld1_w,
  input logic             os_any_w,
  input logic             load_now
);

  // R5
  uflow_reload_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> (count_o == latch_q));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && os_any_w) |-> !start_o);

  // R4
  no_drift_chk: assert property (@(posedge clk) disable iff (rst)
    (!run3_w && !load_now) |=> $stable(count_o));

  // R4
  single_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (run3_w && !load_now && (count_o != '0)) |=>
      (count_o == $past(count_o) - CNT_W'(1)));

  // R2
  fload_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    ld1_w |-> load_now);

endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .underflow_o (underflow_o),
  .start_o     (start_o),
  .count_o     (count_o),
  .latch_q     (latch_q),
  .run3_w      (run3_w),
  .ld1_w       (ld1_w),
  .os_any_w    (os_any_w),
  .load_now    (load_now)
);

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [7:0]   wr_data = 8'd0;
  logic         step_i = 1'b0;
  logic [W-1:0] count_o;
  logic         underflow_o;
  logic         start_o;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivt_timer #(.CNT_W(W)) u_ivt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .step_i(step_i), .count_o(count_o),
    .underflow_o(underflow_o), .start_o(start_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Called at a negedge; returns the index of the write edge.
  task automatic wreg(input logic [1:0] a, input logic [7:0] d, output int e);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    e = cyc;
  endtask

  // Stop, let the pipeline drain, then reload L through the upper-byte path.
  task automatic stop_and_load(input int L);
    int e;
    wreg(2'd2, 8'h00, e);
    repeat (4) tick();
    wreg(2'd0, 8'(L), e);
    wreg(2'd1, 8'(L >> 8), e);
    repeat (2) tick();
  endtask

  initial begin
    int e, w, v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 count", count_o, (1 << W) - 1);
    chk("R1 underflow", underflow_o, 0);
    chk("R1 start", start_o, 0);

    // R3 low byte alone does not load
    wreg(2'd0, 8'd7, e);
    for (int i = 0; i < 3; i++) begin
      chk("R3 low byte no load", count_o, (1 << W) - 1);
      tick();
    end
    // R3 upper byte while stopped loads after two edges
    wreg(2'd1, 8'd0, e);
    chk("R3 write edge", count_o, (1 << W) - 1);
    tick();
    chk("R3 loaded", count_o, 7);

    // R2 force reload
    wreg(2'd0, 8'd9, e);
    repeat (3) begin
      chk("R3 low byte no load", count_o, 7);
      tick();
    end
    wreg(2'd2, 8'h10, e);
    chk("R2 write edge", count_o, 7);
    tick();
    chk("R2 loaded", count_o, 9);

    // R4 R5 R6 continuous sweep over reload values
    for (int L = 0; L <= 6; L++) begin
      string rq;
      rq = (L == 1) ? "R6" : "R5";
      stop_and_load(L);
      chk("R3 reload before start", count_o, L);
      wreg(2'd2, 8'h21, w);
      for (int c = w; c <= w + 4 * (L + 1) + 2; c++) begin
        int first, ec, eu, j;
        first = w + 1 + L;
        if (c < first) begin
          eu = 0;
          ec = (c <= w + 1) ? L : L - (c - w - 1);
        end else begin
          j  = (c - first) % (L + 1);
          eu = (j == 0) ? 1 : 0;
          ec = (j == 0) ? L : L - (j - 1);
        end
        chk({rq, " underflow"}, underflow_o, eu);
        chk("R4 count", count_o, ec);
        chk({rq, " start held"}, start_o, 1);
        tick();
      end
    end

    // R7 one-shot
    stop_and_load(3);
    wreg(2'd2, 8'h29, w);
    for (int c = w; c <= w + 12; c++) begin
      chk("R7 underflow", underflow_o, (c == w + 4) ? 1 : 0);
      chk("R7 start", start_o, (c < w + 4) ? 1 : 0);
      chk("R7 count", count_o, (c < w + 4) ? 3 - ((c <= w + 1) ? 0 : c - w - 1) : 3);
      tick();
    end

    // R8 external step
    stop_and_load(10);
    wreg(2'd2, 8'h01, w);
    repeat (3) begin
      chk("R8 no step hold", count_o, 10);
      tick();
    end
    for (int k = 0; k < 3; k++) begin
      step_i = 1'b1;
      tick();
      step_i = 1'b0;
      chk("R8 step edge", count_o, 10 - k);
      tick();
      chk("R8 after step", count_o, 9 - k);
      tick();
      chk("R8 single dec", count_o, 9 - k);
    end
    step_i = 1'b1;
    repeat (4) tick();
    step_i = 1'b0;
    tick();
    chk("R8 held step", count_o, 3);
    repeat (2) tick();
    chk("R8 held step settle", count_o, 3);
    chk("R8 no underflow", underflow_o, 0);

    // R9 stop latency
    stop_and_load(20);
    wreg(2'd2, 8'h21, w);
    repeat (5) tick();
    v = count_o;
    wreg(2'd2, 8'h20, e);
    chk("R9 write edge", count_o, v - 1);
    chk("R9 start", start_o, 0);
    tick();
    chk("R9 last dec", count_o, v - 2);
    repeat (3) begin
      tick();
      chk("R9 hold", count_o, v - 2);
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule